// File: doc/BRIEF.md
# Power-Management Mailbox Channel with SMI/SCI Pulse Generation

This block is one mailbox channel between an embedded core and a host. The core hands the host a byte through an output buffer, whose full flag (OBF) sets on each load and clears when the host reads it. The host hands the core a byte through an input buffer, whose full flag (IBF) sets on a host write and clears when the core reads it.

The core chooses the data address it uses for the same byte. That choice decides whether the host also gets an SMI pulse, an SCI pulse or no interrupt. Sticky source flags record which interrupt went with the byte now held in the output buffer. Each interrupt line has its own enable, hardware-or-software source select, software level, polarity and programmable pulse length. A single mode bit gates all interrupt generation.

Core register map (3-bit address). Address 0: write loads the byte with no interrupt; read returns the input byte. Address 1: write loads the byte and raises an SMI. Address 2: write loads the byte and raises an SCI; read returns the input byte and raises an SCI. Address 3: read-only status. Addresses 4, 5 and 6: the control, enable and software registers. The configuration registers read back what was written.

Top module: `pm_mbox_chan`

## Requirements
- R1: A core write to address 0 loads `host_odata` with the byte and sets `obf`, and neither `smi_o` nor `sci_o` leaves its idle level.
- R2: With the mode bit set, a core write to address 1 loads the byte, sets `obf`, sets the SMI source flag (status bit 2) and starts an SMI pulse. The SMI flag stays set across later plain loads while `obf` stays set.
- R3: With the mode bit set, a core write to address 2 loads the byte, sets `obf`, sets the SCI source flag (status bit 3) and starts an SCI pulse.
- R4: A `host_rd` strobe clears `obf` and both source flags together, and no source flag is ever set while `obf` is clear. Status register (address 3) layout: bit0 obf, bit1 ibf, bit2 SMI flag, bit3 SCI flag.
- R5: The pulse length code c (control bits [4:3] for SMI, [6:5] for SCI) gives a pulse of exactly 2^c clock cycles. The pulse first shows on the output pin after the second rising edge that follows the triggering edge.
- R6: SMI source select (enable register bit0 = enable, bit1 = hardware select; software register bit0 = software level). When enable and hardware select are both set, the pulse drives the output. When enable is set and hardware select is clear, the software level drives it. When enable is clear, the output is deasserted.
- R7: The SCI source select works the same way, using enable register bit2 (enable), bit3 (hardware select) and software register bit1.
- R8: Polarity bits (control bit1 for SMI, bit2 for SCI). With polarity 0 the line is active low and idles high. With polarity 1 it is active high.
- R9: A `host_wr` strobe stores `host_wdata` and sets `ibf`. A core read of address 0 or address 2 returns that byte and clears `ibf`. Only the address 2 read, with the mode bit set, raises an SCI pulse.
- R10: With the mode bit (control bit0) clear, the outputs stay at their idle level whatever the enables and software bits are. Writes to addresses 1 and 2 still load the byte and set `obf`, but set no source flag and raise no pulse, and a read of address 2 raises no pulse.
- R11: A new trigger that arrives while a pulse is running restarts the full pulse length, and the output stays asserted throughout.
- R12: After reset, `obf`, `ibf` and all configuration bits are 0, and both interrupt outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_we | input | 1 | Core register write strobe |
| core_re | input | 1 | Core register read strobe |
| core_addr | input | ADDR_W | Core register address |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Core read data, registered one cycle after `core_re` |
| host_rd | input | 1 | Host read strobe of the output buffer |
| host_wr | input | 1 | Host write strobe of the input buffer |
| host_wdata | input | DATA_W | Host byte for the input buffer |
| host_odata | output | DATA_W | Output buffer byte seen by the host |
| obf | output | 1 | Output buffer full |
| ibf | output | 1 | Input buffer full |
| smi_o | output | 1 | SMI line, polarity programmable |
| sci_o | output | 1 | SCI line, polarity programmable |

## Verification
The bench builds the block with its defaults: 8-bit data and 2-bit length codes, which makes the longest pulse 8 cycles. With only four length codes and four source-select bits per line, the bench sweeps every length code on both lines. It also sweeps all sixteen enable, hardware-select, software-level and polarity combinations for each line, and it counts asserted cycles in a fixed window against 2^c, the window length or zero. Short pulses also make the restart case cheap to check: a second trigger two cycles after the first must give exactly two extra cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // core register addresses; the three data addresses carry behaviour
  localparam int A_DATA = 0;
  localparam int A_DSMI = 1;
  localparam int A_DSCI = 2;
  localparam int A_STAT = 3;
  localparam int A_CTRL = 4;
  localparam int A_IE   = 5;
  localparam int A_SW   = 6;

  localparam int NSRC    = 2;
  localparam int SRC_SMI = 0;
  localparam int SRC_SCI = 1;
endpackage

// File: rtl/pmc_pulse.sv
module pmc_pulse #(
  parameter int LEN_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (trig) begin
      cnt_q <= CNT_W'(1) << len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = (cnt_q != '0);

  // R11
  pulse_restart_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> busy);
endmodule

// File: rtl/pmc_src_mux.sv
module pmc_src_mux (
  input  logic clk,
  input  logic rst,
  input  logic mode_en,
  input  logic en,
  input  logic hw_sel,
  input  logic sw_lvl,
  input  logic pol,
  input  logic pulse,
  output logic out_q
);
  logic asserted;

  always_comb begin
    asserted = 1'b0;
    if (mode_en && en) begin
      asserted = hw_sel ? pulse : sw_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
    end else begin
      out_q <= pol ? asserted : ~asserted;
    end
  end

  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (out_q == !$past(pol)));
endmodule

// File: rtl/pmc_mailbox.sv
module pmc_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_smi,
  input  logic              set_sci,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              din_rd,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] din,
  output logic              obf,
  output logic              ibf,
  output logic              obf_smi,
  output logic              obf_sci
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      obf     <= 1'b0;
      obf_smi <= 1'b0;
      obf_sci <= 1'b0;
    end else if (load) begin
      dout    <= wdata;
      obf     <= 1'b1;
      obf_smi <= obf_smi | set_smi;
      obf_sci <= obf_sci | set_sci;
    end else if (host_rd) begin
      obf     <= 1'b0;
      obf_smi <= 1'b0;
      obf_sci <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din <= '0;
      ibf <= 1'b0;
    end else if (host_wr) begin
      din <= host_wdata;
      ibf <= 1'b1;
    end else if (din_rd) begin
      ibf <= 1'b0;
    end
  end

  // R1
  obf_set_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (obf && dout == $past(wdata)));

  // R4
  flag_tie_chk: assert property (@(posedge clk) disable iff (rst)
    (obf_smi || obf_sci) |-> obf);

  // R9
  ibf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (din_rd && !host_wr) |=> !ibf);
endmodule

// File: rtl/pm_mbox_chan.sv
module pm_mbox_chan #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_we,
  input  logic              core_re,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_odata,
  output logic              obf,
  output logic              ibf,
  output logic              smi_o,
  output logic              sci_o
);
  import pmc_pkg::*;

  localparam int MAX_LEN = 1 << ((1 << LEN_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int CTRL_W  = 3 + 2 * LEN_W;
  localparam int IE_W    = 2 * NSRC;

  logic [CTRL_W-1:0] ctrl_q;
  logic [IE_W-1:0]   ie_q;
  logic [NSRC-1:0]   sw_q;

  logic mode_en;
  logic a_data, a_dsmi, a_dsci;
  logic load, set_smi, set_sci, din_rd, sci_rd;
  logic mb_smi, mb_sci;
  logic [DATA_W-1:0] din;

  logic [NSRC-1:0] trig, busy, en_b, hw_b, pol_b, irq_out;
  logic [LEN_W-1:0] len_a [NSRC];

  assign mode_en = ctrl_q[0];
  assign a_data  = (core_addr == ADDR_W'(A_DATA));
  assign a_dsmi  = (core_addr == ADDR_W'(A_DSMI));
  assign a_dsci  = (core_addr == ADDR_W'(A_DSCI));

  assign load    = core_we && (a_data || a_dsmi || a_dsci);
  assign set_smi = core_we && a_dsmi && mode_en;
  assign set_sci = core_we && a_dsci && mode_en;
  assign din_rd  = core_re && (a_data || a_dsci);
  assign sci_rd  = core_re && a_dsci && mode_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ie_q   <= '0;
      sw_q   <= '0;
    end else if (core_we) begin
      if (core_addr == ADDR_W'(A_CTRL)) ctrl_q <= core_wdata[CTRL_W-1:0];
      if (core_addr == ADDR_W'(A_IE))   ie_q   <= core_wdata[IE_W-1:0];
      if (core_addr == ADDR_W'(A_SW))   sw_q   <= core_wdata[NSRC-1:0];
    end
  end

  pmc_mailbox #(.DATA_W(DATA_W)) u_mbox (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .wdata      (core_wdata),
    .set_smi    (set_smi),
    .set_sci    (set_sci),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .din_rd     (din_rd),
    .dout       (host_odata),
    .din        (din),
    .obf        (obf),
    .ibf        (ibf),
    .obf_smi    (mb_smi),
    .obf_sci    (mb_sci)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rdata <= '0;
    end else if (core_re) begin
      if (a_data || a_dsci)                    core_rdata <= din;
      else if (core_addr == ADDR_W'(A_STAT))   core_rdata <= DATA_W'({mb_sci, mb_smi, ibf, obf});
      else if (core_addr == ADDR_W'(A_CTRL))   core_rdata <= DATA_W'(ctrl_q);
      else if (core_addr == ADDR_W'(A_IE))     core_rdata <= DATA_W'(ie_q);
      else if (core_addr == ADDR_W'(A_SW))     core_rdata <= DATA_W'(sw_q);
      else                                     core_rdata <= '0;
    end
  end

  assign trig[SRC_SMI] = set_smi;
  assign trig[SRC_SCI] = set_sci || sci_rd;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign en_b[s]  = ie_q[2*s];
      assign hw_b[s]  = ie_q[2*s+1];
      assign pol_b[s] = ctrl_q[1+s];
      assign len_a[s] = ctrl_q[3+s*LEN_W +: LEN_W];

      pmc_pulse #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .trig (trig[s]),
        .len  (len_a[s]),
        .busy (busy[s])
      );

      pmc_src_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .mode_en (mode_en),
        .en      (en_b[s]),
        .hw_sel  (hw_b[s]),
        .sw_lvl  (sw_q[s]),
        .pol     (pol_b[s]),
        .pulse   (busy[s]),
        .out_q   (irq_out[s])
      );
    end
  endgenerate

  assign smi_o = irq_out[SRC_SMI];
  assign sci_o = irq_out[SRC_SCI];

  // R2
  smi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    set_smi |=> mb_smi);

  // R3
  sci_flag_chk: assert property (@(posedge clk) disable iff (rst)
    set_sci |=> mb_sci);
endmodule

// File: tb/test_pm_mbox_chan.sv
`timescale 1ns/1ps
module test_pm_mbox_chan;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       core_we = 1'b0, core_re = 1'b0;
  logic [2:0] core_addr = '0;
  logic [7:0] core_wdata = '0, core_rdata;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0, host_odata;
  logic       obf, ibf, smi_o, sci_o;

  int checks = 0, errors = 0;
  int smi_hits = 0, sci_hits = 0;
  logic smi_act = 1'b0, sci_act = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_mbox_chan i_pm_mbox_chan (
    .clk(clk), .rst(rst), .core_we(core_we), .core_re(core_re),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_odata(host_odata), .obf(obf), .ibf(ibf), .smi_o(smi_o), .sci_o(sci_o)
  );

  // counts cycles spent at the active level, seen just before each edge
  always @(posedge clk) begin
    if (smi_o == smi_act) smi_hits++;
    if (sci_o == sci_act) sci_hits++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    core_addr = 3'(a); core_wdata = 8'(d); core_we = 1'b1;
    @(negedge clk);
    core_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    core_addr = 3'(a); core_re = 1'b1;
    @(negedge clk);
    core_re = 1'b0;
    d = int'(core_rdata);
  endtask

  task automatic hread();
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic hwrite(input int d);
    host_wdata = 8'(d); host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctrl_val(int mode, int spol, int cpol, int slen, int clen);
    return mode | (spol << 1) | (cpol << 2) | (slen << 3) | (clen << 5);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v;
    idle(3);
    rst = 1'b0;
    // R12 reset state
    check("R12 obf", obf, 0);
    check("R12 ibf", ibf, 0);
    check("R12 smi_o", smi_o, 1);
    check("R12 sci_o", sci_o, 1);
    rd(3, v); check("R12 status", v, 0);
    rd(4, v); check("R12 ctrl", v, 0);
    rd(5, v); check("R12 ie", v, 0);

    // R1 plain loads under several byte patterns, both lines armed in hardware
    wr(4, ctrl_val(1, 0, 0, 0, 0));
    wr(5, 4'b1111);
    for (int k = 0; k < 6; k++) begin
      int d = (k * 8'h4B + 8'h11) & 8'hFF;
      smi_hits = 0; sci_hits = 0;
      wr(0, d);
      check("R1 host_odata", host_odata, d);
      check("R1 obf", obf, 1);
      idle(13);
      check("R1 no smi", smi_hits, 0);
      check("R1 no sci", sci_hits, 0);
      rd(3, v); check("R1 status", v, 1);
      hread();
      check("R4 obf cleared", obf, 0);
    end

    // R2 R3 R5: every length code on both lines
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        wr(4, ctrl_val(1, 0, 0, c, c));
        smi_hits = 0; sci_hits = 0;
        wr(s == 0 ? 1 : 2, 8'hA0 + c);
        check(s == 0 ? "R5 smi not yet" : "R5 sci not yet", s == 0 ? smi_o : sci_o, 1);
        idle(1);
        check(s == 0 ? "R5 smi started" : "R5 sci started", s == 0 ? smi_o : sci_o, 0);
        idle(12);
        if (s == 0) begin
          check("R2 R5 smi width", smi_hits, 1 << c);
          check("R2 no sci", sci_hits, 0);
        end else begin
          check("R3 R5 sci width", sci_hits, 1 << c);
          check("R3 no smi", smi_hits, 0);
        end
        check("R2 R3 host_odata", host_odata, 8'hA0 + c);
        rd(3, v); check(s == 0 ? "R2 status" : "R3 status", v, s == 0 ? 5 : 9);
        hread();
        rd(3, v); check("R4 flags cleared", v, 0);
      end
    end

    // R2 SMI flag survives a later plain load
    wr(4, ctrl_val(1, 0, 0, 0, 0));
    wr(1, 8'h01);
    wr(0, 8'h02);
    rd(3, v); check("R2 sticky flag", v, 5);
    hread();
    rd(3, v); check("R4 sticky cleared", v, 0);

    // R6 R7 R8: all source-select and polarity combinations per line
    for (int s = 0; s < 2; s++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        int en = cfg & 1, hw = (cfg >> 1) & 1, sw = (cfg >> 2) & 1, pol = (cfg >> 3) & 1;
        int asrt, lvl, exp_hits;
        wr(4, ctrl_val(1, s == 0 ? pol : 0, s == 1 ? pol : 0, 0, 0));
        wr(5, (en | (hw << 1)) << (2 * s));
        wr(6, sw << s);
        idle(2);
        asrt = en & (hw == 0 ? sw : 0);
        lvl  = pol != 0 ? asrt : 1 - asrt;
        check(s == 0 ? "R6 R8 smi level" : "R7 R8 sci level", s == 0 ? smi_o : sci_o, lvl);
        check(s == 0 ? "R6 other idle" : "R7 other idle", s == 0 ? sci_o : smi_o, 1);
        if (s == 0) smi_act = 1'(pol); else sci_act = 1'(pol);
        smi_hits = 0; sci_hits = 0;
        wr(s == 0 ? 1 : 2, cfg);
        idle(13);
        exp_hits = en == 0 ? 0 : (hw != 0 ? 1 : (sw != 0 ? 14 : 0));
        check(s == 0 ? "R6 R8 smi cycles" : "R7 R8 sci cycles",
              s == 0 ? smi_hits : sci_hits, exp_hits);
        hread();
      end
      smi_act = 1'b0; sci_act = 1'b0;
    end
    wr(6, 0);

    // R9 input buffer, plain and SCI read addresses
    wr(4, ctrl_val(1, 0, 0, 0, 1));
    wr(5, 4'b1111);
    hwrite(8'h3C);
    check("R9 ibf set", ibf, 1);
    smi_hits = 0; sci_hits = 0;
    rd(0, v);
    check("R9 plain read data", v, 8'h3C);
    check("R9 ibf cleared", ibf, 0);
    idle(13);
    check("R9 plain read no sci", sci_hits, 0);
    hwrite(8'hC3);
    smi_hits = 0; sci_hits = 0;
    rd(2, v);
    check("R9 sci read data", v, 8'hC3);
    check("R9 ibf cleared sci", ibf, 0);
    idle(13);
    check("R9 sci read pulse", sci_hits, 2);
    check("R9 no smi", smi_hits, 0);

    // R10 mode bit clear
    wr(4, ctrl_val(0, 0, 0, 2, 2));
    wr(6, 2'b11);
    idle(2);
    check("R10 smi idle", smi_o, 1);
    check("R10 sci idle", sci_o, 1);
    smi_hits = 0; sci_hits = 0;
    wr(1, 8'h77);
    check("R10 obf", obf, 1);
    check("R10 data", host_odata, 8'h77);
    wr(2, 8'h78);
    hwrite(8'h12);
    rd(2, v);
    check("R10 read data", v, 8'h12);
    idle(12);
    check("R10 no smi", smi_hits, 0);
    check("R10 no sci", sci_hits, 0);
    rd(3, v); check("R10 no flags", v, 1);
    hread();
    wr(6, 0);

    // R11 retrigger two cycles into a 4-cycle pulse
    wr(4, ctrl_val(1, 0, 0, 2, 2));
    smi_hits = 0; sci_hits = 0;
    wr(1, 8'h01);
    idle(1);
    wr(1, 8'h02);
    idle(12);
    check("R11 smi restart", smi_hits, 6);
    smi_hits = 0; sci_hits = 0;
    wr(2, 8'h03);
    idle(1);
    wr(2, 8'h04);
    idle(12);
    check("R11 sci restart", sci_hits, 6);
    hread();

    finish_run();
  end
endmodule